// File: doc/BRIEF.md
# Colour Channel Gain/Offset Rotation Sequencer

This block decides which of three colour channels (red, green, blue) an image-sensor front end is working on, and hands the analog stage that channel's 6-bit gain code and 8-bit offset code. It runs on a system clock. The pixel boundary arrives as a one-cycle `pix_tick` pulse, which marks the falling edge of the pixel clock. The line-start strobe `line_sync` is a level. A 2-bit configuration field picks one of four rotation policies:

- `00`: fixed red.
- `01`: the input stays on red while the coefficients rotate per pixel.
- `10`: input and coefficients rotate together per pixel.
- `11`: input and coefficients rotate once per line.

The six coefficient registers are presented as flat vectors. Channel index 0 (red) sits in the low bits: gain bits [5:0] red, [11:6] green, [17:12] blue; offset bits [7:0] red, [15:8] green, [23:16] blue. The colour index encoding is 0 = red, 1 = green, 2 = blue. The block has no data stream. Every pin is a plain control or code signal, so the block applies no back-pressure and needs no handshake.

The selected gain and offset are held in output registers. These registers load only at an update point, so a code stays constant for a whole pixel or line even if software rewrites a coefficient register in between. An update point is one of the following: the colour changes, the line strobe is high, a mode write occurs, or the first cycle after reset.

Top module: `color_rotation_seq`

## Requirements
- R1: While `rst_n` is low, `chan_idx`, `gain_out`, `offs_out` and `sample_all` are all 0.
- R2: With configuration 00, `chan_idx` stays 0 and the outputs carry the red gain and offset whatever `pix_tick` does.
- R3: With configuration 01, `chan_idx` stays 0 (red input), while the coefficient colour steps red→green→blue→red on each `pix_tick`, taking effect at the clock edge that samples the tick.
- R4: With configuration 10, `chan_idx` and the coefficient colour step together red→green→blue→red on each `pix_tick`, at the edge that samples the tick.
- R5: In configurations 01 and 10, every edge that samples `line_sync` high selects red, and `pix_tick` has no effect during that cycle.
- R6: With configuration 11, the colour steps red→green→blue→red on each falling edge of `line_sync`, seen at the edge after the first low sample, and `pix_tick` has no effect.
- R7: A `mode_wr` pulse with configuration 11 selects red at that edge, taking priority over a coincident `line_sync` falling edge.
- R8: With configuration 10, `sample_all` is high for exactly one cycle after each `pix_tick` sampled while red is active and `line_sync` is low, which is every third tick of an undisturbed run.
- R9: `gain_out` and `offs_out` change only at an update point: a colour change, `line_sync` high, `mode_wr`, or the first edge after reset. A coefficient register rewritten between update points is not seen.
- R10: At each update point, `gain_out` and `offs_out` take the register values of the colour selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_tick | input | 1 | One-cycle pulse at each pixel boundary |
| line_sync | input | 1 | Line-start strobe (level) |
| cfg | input | 2 | Rotation policy 00/01/10/11 |
| mode_wr | input | 1 | Pulse marking a write of the mode register |
| gain_regs | input | 18 | Gain codes, red in bits [5:0], green [11:6], blue [17:12] |
| offs_regs | input | 24 | Offset codes, red in bits [7:0], green [15:8], blue [23:16] |
| chan_idx | output | 2 | Selected input channel, 0 red, 1 green, 2 blue |
| gain_out | output | 6 | Gain code for the analog stage |
| offs_out | output | 8 | Offset code for the analog stage |
| sample_all | output | 1 | Simultaneous three-channel sample strobe |

## Verification
The hardest situation to reach from the ports is a collision of update sources. One case is a mode write landing on the same edge as a line-strobe falling edge in line mode. Another is a coefficient rewrite that falls between two update points. The stimulus sweeps each configuration with interleaved pixel-tick, line-strobe and mode-write patterns of coprime periods, so these coincidences recur, and it rewrites the coefficient registers partway through each sweep. A bench model derived from the requirements predicts the outputs every cycle. A directed sequence then holds configuration 10 quiet while the red gain changes, proving that the held code does not move.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    CFG_FIXED    = 2'd0,
    CFG_COEF_ROT = 2'd1,
    CFG_PIX_ROT  = 2'd2,
    CFG_LINE_ROT = 2'd3
  } rot_cfg_e;
endpackage

// File: rtl/crs_color_ptr.sv
module crs_color_ptr
  import crs_pkg::*;
#(
  parameter int NCH = 3,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_tick,
  input  logic          line_sync,
  input  logic          mode_wr,
  input  rot_cfg_e      cfg,
  output logic [CW-1:0] cur_q,
  output logic [CW-1:0] cur_nxt,
  output logic          sample_q
);
  logic          line_q;
  logic [CW-1:0] cur_inc;

  assign cur_inc = (cur_q == CW'(NCH-1)) ? '0 : cur_q + CW'(1);

  always_comb begin
    cur_nxt = cur_q;
    if (mode_wr && cfg == CFG_LINE_ROT) begin
      cur_nxt = '0;
    end else begin
      unique case (cfg)
        CFG_FIXED:    cur_nxt = '0;
        CFG_COEF_ROT,
        CFG_PIX_ROT:  begin
          if (line_sync)     cur_nxt = '0;
          else if (pix_tick) cur_nxt = cur_inc;
        end
        CFG_LINE_ROT: if (line_q && !line_sync) cur_nxt = cur_inc;
        default:      cur_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      line_q   <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      cur_q    <= cur_nxt;
      line_q   <= line_sync;
      sample_q <= (cfg == CFG_PIX_ROT) && pix_tick && !line_sync && (cur_q == '0);
    end
  end
endmodule

// File: rtl/crs_coef_hold.sv
module crs_coef_hold #(
  parameter int NCH = 3,
  parameter int GW  = 6,
  parameter int OW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH*GW-1:0] gain_regs,
  input  logic [NCH*OW-1:0] offs_regs,
  input  logic [CW-1:0]  cur_q,
  input  logic [CW-1:0]  cur_nxt,
  input  logic           force_load,
  output logic [GW-1:0]  gain_out,
  output logic [OW-1:0]  offs_out
);
  logic [GW-1:0] gain_arr [NCH];
  logic [OW-1:0] offs_arr [NCH];
  logic          primed;
  logic          load;

  for (genvar c = 0; c < NCH; c++) begin : g_unpack
    assign gain_arr[c] = gain_regs[c*GW +: GW];
    assign offs_arr[c] = offs_regs[c*OW +: OW];
  end

  assign load = !primed || force_load || (cur_nxt != cur_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      gain_out <= '0;
      offs_out <= '0;
    end else begin
      primed <= 1'b1;
      if (load) begin
        gain_out <= gain_arr[cur_nxt];
        offs_out <= offs_arr[cur_nxt];
      end
    end
  end
endmodule

// File: rtl/color_rotation_seq.sv
module color_rotation_seq
  import crs_pkg::*;
#(
  parameter int NCH = 3,
  parameter int GW  = 6,
  parameter int OW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_tick,
  input  logic              line_sync,
  input  logic [1:0]        cfg,
  input  logic              mode_wr,
  input  logic [NCH*GW-1:0] gain_regs,
  input  logic [NCH*OW-1:0] offs_regs,
  output logic [CW-1:0]     chan_idx,
  output logic [GW-1:0]     gain_out,
  output logic [OW-1:0]     offs_out,
  output logic              sample_all
);
  rot_cfg_e      cfg_e;
  logic [CW-1:0] cur_q;
  logic [CW-1:0] cur_nxt;

  assign cfg_e = rot_cfg_e'(cfg);

  crs_color_ptr #(.NCH(NCH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_tick (pix_tick),
    .line_sync(line_sync),
    .mode_wr  (mode_wr),
    .cfg      (cfg_e),
    .cur_q    (cur_q),
    .cur_nxt  (cur_nxt),
    .sample_q (sample_all)
  );

  crs_coef_hold #(.NCH(NCH), .GW(GW), .OW(OW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .gain_regs (gain_regs),
    .offs_regs (offs_regs),
    .cur_q     (cur_q),
    .cur_nxt   (cur_nxt),
    .force_load(mode_wr || line_sync),
    .gain_out  (gain_out),
    .offs_out  (offs_out)
  );

  assign chan_idx = (cfg_e == CFG_COEF_ROT) ? '0 : cur_q;
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int NCH = 3,
  parameter int GW  = 6,
  parameter int OW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_tick,
  input logic              line_sync,
  input logic [1:0]        cfg,
  input logic              mode_wr,
  input logic [NCH*GW-1:0] gain_regs,
  input logic [NCH*OW-1:0] offs_regs,
  input logic [CW-1:0]     chan_idx,
  input logic [GW-1:0]     gain_out,
  input logic [OW-1:0]     offs_out,
  input logic              sample_all
);
  assert_fixed_red_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg) == 2'd0 && cfg == 2'd0) |-> chan_idx == '0);

  assert_line_red_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && !mode_wr && (cfg == 2'd1 || cfg == 2'd2))
      |=> (gain_out == $past(gain_regs[GW-1:0]) && offs_out == $past(offs_regs[OW-1:0])));

  assert_modewr_red_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && cfg == 2'd3)
      |=> (gain_out == $past(gain_regs[GW-1:0]) && offs_out == $past(offs_regs[OW-1:0])));

  assert_sample_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_all |-> $past(cfg) == 2'd2);

  assert_sample_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_all |=> !sample_all);

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (cfg == 2'd1 || cfg == 2'd2) && !pix_tick && !line_sync && !mode_wr)
      |=> ($stable(gain_out) && $stable(offs_out)));
endmodule

bind color_rotation_seq crs_checker #(.NCH(NCH), .GW(GW), .OW(OW)) u_crs_chk (
  .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .line_sync(line_sync),
  .cfg(cfg), .mode_wr(mode_wr), .gain_regs(gain_regs), .offs_regs(offs_regs),
  .chan_idx(chan_idx), .gain_out(gain_out), .offs_out(offs_out),
  .sample_all(sample_all)
);

// File: tb/color_rotation_seq_test.sv
`timescale 1ns/1ps
module color_rotation_seq_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_tick, line_sync, mode_wr;
  logic [1:0]  cfg;
  logic [17:0] gain_regs;
  logic [23:0] offs_regs;
  logic [1:0]  chan_idx;
  logic [5:0]  gain_out;
  logic [7:0]  offs_out;
  logic        sample_all;

  int checks = 0;
  int fails  = 0;

  // bench model state
  int m_cur, m_lq, m_primed, m_gain, m_offs, m_samp;

  always #(CLK_NS/2) clk = ~clk;

  color_rotation_seq uut (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .line_sync(line_sync),
    .cfg(cfg), .mode_wr(mode_wr), .gain_regs(gain_regs), .offs_regs(offs_regs),
    .chan_idx(chan_idx), .gain_out(gain_out), .offs_out(offs_out),
    .sample_all(sample_all)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int g_of(input int c);
    return int'(gain_regs[c*6 +: 6]);
  endfunction
  function automatic int o_of(input int c);
    return int'(offs_regs[c*8 +: 8]);
  endfunction

  // one cycle: inputs driven now (away from the edge), model advanced, outputs checked after the edge
  task automatic cyc(input bit t, input bit l, input bit w);
    int nxt;
    bit load;
    pix_tick = t; line_sync = l; mode_wr = w;
    nxt = m_cur;
    if (w && cfg == 2'd3) nxt = 0;
    else case (cfg)
      2'd0: nxt = 0;
      2'd1, 2'd2: nxt = l ? 0 : (t ? (m_cur + 1) % 3 : m_cur);
      default: if (m_lq == 1 && !l) nxt = (m_cur + 1) % 3;
    endcase
    load = (m_primed == 0) || (nxt != m_cur) || w || l;
    m_samp = (cfg == 2'd2 && t && !l && m_cur == 0) ? 1 : 0;
    if (load) begin m_gain = g_of(nxt); m_offs = o_of(nxt); end
    m_cur = nxt; m_lq = l; m_primed = 1;
    @(posedge clk); #1;
    begin
      string rq;
      case (cfg)
        2'd0: rq = "R2";
        2'd1: rq = "R3";
        2'd2: rq = "R4";
        default: rq = "R6";
      endcase
      if (w && cfg == 2'd3) rq = "R7";
      else if (l && (cfg == 2'd1 || cfg == 2'd2)) rq = "R5";
      check(chan_idx == ((cfg == 2'd1) ? 0 : m_cur), {rq, " chan"}, chan_idx, (cfg == 2'd1) ? 0 : m_cur);
      check(gain_out == m_gain, {rq, " R10 gain"}, gain_out, m_gain);
      check(offs_out == m_offs, {rq, " R10 offs"}, offs_out, m_offs);
      check(sample_all == m_samp, "R8 sample_all", sample_all, m_samp);
    end
    pix_tick = 0; line_sync = 0; mode_wr = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; pix_tick = 0; line_sync = 0; mode_wr = 0; cfg = 2'd0;
    gain_regs = {6'd42, 6'd17, 6'd5};
    offs_regs = {8'hF3, 8'h82, 8'h11};
    m_cur = 0; m_lq = 0; m_primed = 0; m_gain = 0; m_offs = 0; m_samp = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(chan_idx == 0 && sample_all == 0, "R1 chan/sample", chan_idx, 0);
    check(gain_out == 0 && offs_out == 0, "R1 codes", gain_out, 0);
    rst_n = 1;

    // near-exhaustive sweeps over every configuration and event pattern
    for (int c = 0; c < 4; c++) begin
      cfg = 2'(c);
      for (int i = 0; i < 200; i++) begin
        if (i == 90) begin
          gain_regs = {6'(c*7+3), 6'(c*5+33), 6'(c*11+1)};
          offs_regs = {8'(c*29+7), 8'(c*3+200), 8'(c*17+64)};
        end
        cyc(((i % 3) != 1) || ((i % 7) == 0), (i % 13) < 2, (i % 23) == 11);
      end
    end

    // R7: mode write coincident with line falling edge in line mode
    cfg = 2'd3;
    cyc(0, 1, 0);
    cyc(0, 0, 1);
    check(chan_idx == 0, "R7 write beats line fall", chan_idx, 0);

    // R6: three clean line strobes walk green, blue, red
    for (int k = 1; k <= 3; k++) begin
      cyc(0, 1, 0);
      cyc(1, 0, 0);
      check(chan_idx == (k % 3), "R6 line step", chan_idx, k % 3);
    end

    // R8 / R4: undisturbed run in cfg 10 samples every third tick
    cfg = 2'd2;
    cyc(0, 1, 0);
    for (int k = 0; k < 9; k++) begin
      cyc(1, 0, 0);
      check(sample_all == (k % 3 == 0), "R8 cadence", sample_all, k % 3 == 0);
    end

    // R9: rewrite red gain while quiet; held code must not move
    cyc(0, 1, 0);
    gain_regs[5:0] = 6'd60;
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    check(gain_out != 6'd60, "R9 held code", gain_out, m_gain);
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
    check(gain_out == 6'd60, "R10 new code at red", gain_out, 60);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule